// File: doc/BRIEF.md
# Serial EEPROM Slave (1 KB, two-wire bus)

This block answers on a two-wire serial bus (SCL and SDA) as a 1 KB byte-addressable non-volatile memory. The storage is an on-chip register array organised as four blocks of 256 bytes. A master reaches a byte by sending a control byte, then one byte of offset. The control byte carries a fixed device-type nibble, the block number and the transfer direction. The slave keeps an internal pointer, so writes and reads may follow on from where the last access stopped.

Written data is first collected in a 16-byte page buffer. It reaches the array only when the master sends STOP. That STOP also starts a write cycle of programmable length. While the write cycle runs, the slave refuses every control byte. A master can therefore poll with control bytes until one is acknowledged. Both pins are sampled with the system clock through a synchroniser. The SDA output is an open-drain enable: 1 pulls the line low.

Top module: `serial_eeprom_slave`

## Requirements
- R1: A control byte is acknowledged only when its bits 7:4 equal 1010 and no write cycle is running. Bit 3 is ignored. For any other pattern SDA stays released in the ninth clock, and the slave ignores the bus until the next START.
- R2: Control byte bits 2:1 select the block and bit 0 is the direction (0 = write, 1 = read). Together with the following offset byte they form the 10-bit location {block, offset}. Each block holds its own data.
- R3: Byte write is a write-mode control byte, an offset and one data byte, each acknowledged, followed by STOP. Once the write cycle ends, a read of that location returns the data.
- R4: A page write takes up to 16 data bytes. The offset wraps inside the aligned 16-byte page and never crosses into the next page. Bytes past the sixteenth overwrite the earliest ones.
- R5: A STOP that ends a transfer carrying data starts a write cycle of WRITE_CYCLES clocks. A control byte sent right after that STOP is not acknowledged. Control bytes are acknowledged again once the cycle ends.
- R6: A STOP with no data byte after the offset starts no write cycle. The next control byte is acknowledged at once.
- R7: A read-mode control byte with no offset byte returns the byte at the internal pointer. The pointer advances by one after every byte written or read.
- R8: Random read is a write-mode control byte, an offset, a repeated START and a read-mode control byte, each acknowledged. The data at that offset follows.
- R9: In a read, each master ACK makes the slave send the byte at the next location. The pointer wraps from location 1023 to 0. After a master NACK and STOP, SDA stays released.
- R10: After reset every location reads 0xFF and SDA is released.
- R11: SDA is sampled on the SCL rising edge. The SDA drive changes only while SCL is low.
- R12: A repeated START after data bytes discards them. The following STOP commits nothing and starts no write cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | Open-drain enable, 1 pulls SDA low |

## Verification
Both bus inputs pass through two synchroniser flops and one edge-detect register. The acknowledge, the first data bit and the release of SDA therefore appear three to four system clocks after the SCL fall that triggers them. The bench models the master with a quarter bit of six clocks. It changes SDA six clocks after each SCL fall and samples the bus eighteen clocks after the fall, in the middle of the SCL high phase, so every result is settled when it is read. A write becomes visible only after the write cycle. The bench finds that point by acknowledge polling instead of counting cycles, and it checks that the first poll after each STOP is refused.

// File: rtl/eep_pkg.sv
// Shared types for the serial EEPROM slave.
// Assumes: the control byte layout is fixed, with the device nibble in bits 7:4.
package eep_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } bus_state_t;

    typedef enum logic [1:0] {
        K_CTRL,
        K_ADDR,
        K_DATA
    } rx_kind_t;

    localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/eep_bus_monitor.sv
// Synchronises SCL and SDA to clk and flags SCL edges and START/STOP.
// Assumes: SYNC_STAGES >= 2 and the bus is idle (both high) out of reset.
module eep_bus_monitor #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_sync;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic                   scl_prev;
    logic                   sda_prev;

    // Synchroniser chains plus one stage of history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_sync <= (scl_sync << 1) | SYNC_STAGES'(scl_i);
            sda_sync <= (sda_sync << 1) | SYNC_STAGES'(sda_i);
            scl_prev <= scl_lvl;
            sda_prev <= sda_lvl;
        end
    end

    // Event decode from the synchronised levels.
    always_comb begin
        scl_lvl   = scl_sync[SYNC_STAGES-1];
        sda_lvl   = sda_sync[SYNC_STAGES-1];
        scl_rise  = scl_lvl & ~scl_prev;
        scl_fall  = ~scl_lvl & scl_prev;
        start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
        stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
    end
endmodule

// File: rtl/eep_page_buffer.sv
// Holds the data bytes of one page write until STOP commits them.
// Assumes: the offset wraps inside the page, so a later byte at the same offset replaces an earlier one.
module eep_page_buffer #(
    parameter int PAGE_BYTES = 16,
    localparam int PG_W = $clog2(PAGE_BYTES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clear,
    input  logic                        wr_en,
    input  logic [PG_W-1:0]             wr_off,
    input  logic [7:0]                  wr_data,
    output logic [PAGE_BYTES-1:0][7:0]  page_data,
    output logic [PAGE_BYTES-1:0]       page_valid
);
    // Capture one data byte per write and mark its slot as pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_data  <= '0;
            page_valid <= '0;
        end else if (clear) begin
            page_valid <= '0;
        end else if (wr_en) begin
            page_data[wr_off]  <= wr_data;
            page_valid[wr_off] <= 1'b1;
        end
    end

    assert_write_not_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !clear) else $error("buffer write coincides with clear");
    assert_slot_marked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> page_valid[$past(wr_off)]) else $error("written slot not marked");
endmodule

// File: rtl/eep_mem_array.sv
// Byte array of the memory. Reads are combinational. A commit writes every pending slot of one page in a single cycle.
// Assumes: DEPTH == 2**PTR_W and the page is aligned on PAGE_BYTES.
module eep_mem_array #(
    parameter int DEPTH      = 1024,
    parameter int PAGE_BYTES = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int PG_W  = $clog2(PAGE_BYTES),
    localparam int SEL_W = PTR_W - PG_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [PTR_W-1:0]           rd_addr,
    output logic [7:0]                 rd_data,
    input  logic                       commit,
    input  logic [SEL_W-1:0]           page_sel,
    input  logic [PAGE_BYTES-1:0][7:0] page_data,
    input  logic [PAGE_BYTES-1:0]      page_valid
);
    logic [7:0] cells [DEPTH];

    // Erase on reset and commit a buffered page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
        end else if (commit) begin
            for (int j = 0; j < PAGE_BYTES; j++) begin
                if (page_valid[j]) cells[{page_sel, PG_W'(j)}] <= page_data[j];
            end
        end
    end

    // Read port.
    assign rd_data = cells[rd_addr];

    assert_commit_has_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (page_valid != '0)) else $error("commit without pending data");
endmodule

// File: rtl/eep_write_timer.sv
// Counts down the internal write cycle. busy is high while the count is nonzero.
// Assumes: WRITE_CYCLES >= 1 and start is only raised while idle.
module eep_write_timer #(
    parameter int WRITE_CYCLES = 500,
    localparam int CNT_W = $clog2(WRITE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    logic [CNT_W-1:0] remaining;

    // Load on start and count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                remaining <= '0;
        else if (start)            remaining <= CNT_W'(WRITE_CYCLES);
        else if (remaining != '0)  remaining <= remaining - CNT_W'(1);
    end

    assign busy = (remaining != '0);

    assert_start_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy) else $error("write cycle restarted while busy");
    assert_busy_follows_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy) else $error("start did not raise busy");
endmodule

// File: rtl/serial_eeprom_slave.sv
// Two-wire bus slave that behaves as a 1 KB EEPROM in blocks of 256 bytes.
// Decodes the control byte, keeps the pointer, shifts bytes in and out, drives acknowledges,
// commits a page on STOP and refuses control bytes while the write cycle runs.
// Assumes: clk is at least about 20 times the SCL rate, and there is no clock stretching and no 10-bit addressing.
module serial_eeprom_slave #(
    parameter int BLOCKS       = 4,
    parameter int BLOCK_BYTES  = 256,
    parameter int PAGE_BYTES   = 16,
    parameter int WRITE_CYCLES = 500,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    import eep_pkg::*;

    localparam int BLK_W = $clog2(BLOCKS);
    localparam int OFF_W = $clog2(BLOCK_BYTES);
    localparam int PTR_W = BLK_W + OFF_W;
    localparam int DEPTH = BLOCKS * BLOCK_BYTES;
    localparam int PG_W  = $clog2(PAGE_BYTES);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic busy, commit, buf_clear, buf_wr, ctrl_hit, master_ack, rd_mode;
    logic [PAGE_BYTES-1:0][7:0] page_data;
    logic [PAGE_BYTES-1:0]      page_valid;
    logic [7:0]       rd_data, rx_sh, tx_sh;
    logic [3:0]       bit_cnt;
    logic [PTR_W-1:0] ptr;
    bus_state_t       state;
    rx_kind_t         kind;

    eep_bus_monitor #(.SYNC_STAGES(SYNC_STAGES)) i_mon (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det));

    eep_page_buffer #(.PAGE_BYTES(PAGE_BYTES)) i_buf (
        .clk(clk), .rst_n(rst_n), .clear(buf_clear), .wr_en(buf_wr),
        .wr_off(ptr[PG_W-1:0]), .wr_data(rx_sh),
        .page_data(page_data), .page_valid(page_valid));

    eep_mem_array #(.DEPTH(DEPTH), .PAGE_BYTES(PAGE_BYTES)) i_mem (
        .clk(clk), .rst_n(rst_n), .rd_addr(ptr), .rd_data(rd_data),
        .commit(commit), .page_sel(ptr[PTR_W-1:PG_W]),
        .page_data(page_data), .page_valid(page_valid));

    eep_write_timer #(.WRITE_CYCLES(WRITE_CYCLES)) i_tmr (
        .clk(clk), .rst_n(rst_n), .start(commit), .busy(busy));

    // Control decode, buffer strobes and the commit request.
    always_comb begin
        ctrl_hit  = (rx_sh[7:4] == DEV_CODE) && !busy;
        buf_clear = start_det || stop_det;
        commit    = stop_det && (page_valid != '0) && !busy;
        buf_wr    = !start_det && !stop_det && (state == ST_RX) && (kind == K_DATA)
                    && scl_fall && (bit_cnt == 4'd8);
    end

    // Bit and byte sequencer: receive, acknowledge, transmit and pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            kind       <= K_CTRL;
            bit_cnt    <= '0;
            rx_sh      <= '0;
            tx_sh      <= '0;
            ptr        <= '0;
            rd_mode    <= 1'b0;
            master_ack <= 1'b0;
            sda_oe     <= 1'b0;
        end else if (start_det) begin
            state   <= ST_RX;
            kind    <= K_CTRL;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
        end else if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                ST_RX: begin
                    if (scl_rise) begin
                        rx_sh   <= {rx_sh[6:0], sda_lvl};
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (scl_fall && bit_cnt == 4'd8) begin
                        case (kind)
                            K_CTRL: begin
                                if (ctrl_hit) begin
                                    sda_oe               <= 1'b1;
                                    state                <= ST_RX_ACK;
                                    rd_mode              <= rx_sh[0];
                                    ptr[PTR_W-1:OFF_W]   <= rx_sh[BLK_W:1];
                                    kind                 <= K_ADDR;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end
                            K_ADDR: begin
                                ptr[OFF_W-1:0] <= rx_sh[OFF_W-1:0];
                                sda_oe         <= 1'b1;
                                state          <= ST_RX_ACK;
                                kind           <= K_DATA;
                            end
                            default: begin
                                ptr[PG_W-1:0] <= ptr[PG_W-1:0] + PG_W'(1);
                                sda_oe        <= 1'b1;
                                state         <= ST_RX_ACK;
                            end
                        endcase
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (rd_mode) begin
                            state  <= ST_TX;
                            tx_sh  <= rd_data;
                            sda_oe <= ~rd_data[7];
                        end else begin
                            state  <= ST_RX;
                            sda_oe <= 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (bit_cnt == 4'd8) begin
                            sda_oe <= 1'b0;
                            state  <= ST_TX_ACK;
                            ptr    <= ptr + PTR_W'(1);
                        end else begin
                            tx_sh  <= {tx_sh[6:0], 1'b0};
                            sda_oe <= ~tx_sh[6];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        master_ack <= ~sda_lvl;
                    end else if (scl_fall) begin
                        if (master_ack) begin
                            state   <= ST_TX;
                            bit_cnt <= '0;
                            tx_sh   <= rd_data;
                            sda_oe  <= ~rd_data[7];
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assert_drive_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_lvl) else $error("SDA drive changed while SCL high");
    assert_busy_nack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RX && kind == K_CTRL && scl_fall && bit_cnt == 4'd8 && busy
         && !start_det && !stop_det) |=> !sda_oe) else $error("control byte acknowledged while busy");
    assert_tx_not_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TX) |-> !busy) else $error("transmitting during write cycle");
endmodule

// File: tb/test_serial_eeprom_slave.sv
module test_serial_eeprom_slave;
    localparam int Q = 6;
    localparam int H = 2 * Q;
    localparam int POLL_LIMIT = 20;
    // {block[17:16], offset[15:8], data[7:0]}
    localparam bit [17:0] VEC [8] = '{
        {2'd0, 8'h00, 8'h11}, {2'd1, 8'h00, 8'h22}, {2'd2, 8'h00, 8'h33}, {2'd3, 8'h00, 8'h44},
        {2'd0, 8'h7F, 8'hA5}, {2'd3, 8'hFF, 8'h5A}, {2'd2, 8'h10, 8'hC3}, {2'd1, 8'hEE, 8'h0F}};

    logic clk = 0, rst_n = 0, scl_m = 1, sda_m = 1;
    logic sda_oe;
    logic sda_bus;
    int checks = 0, fails = 0, drv_viol = 0;
    logic prev_oe = 0;
    bit finished = 0;

    assign sda_bus = sda_m & ~sda_oe;
    always #5 clk = ~clk;

    serial_eeprom_slave i_serial_eeprom_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe));

    // R11: watch for SDA drive changes while SCL is high.
    always @(negedge clk) begin
        if (rst_n && (sda_oe !== prev_oe) && scl_m) drv_viol++;
        prev_oe <= sda_oe;
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bit_out(input logic b);
        wait_clk(Q); sda_m = b; wait_clk(Q); scl_m = 1; wait_clk(H); scl_m = 0;
    endtask

    task automatic bit_in(output logic b);
        wait_clk(Q); sda_m = 1; wait_clk(Q); scl_m = 1; wait_clk(Q); b = sda_bus; wait_clk(Q); scl_m = 0;
    endtask

    task automatic bus_start();
        wait_clk(Q); sda_m = 1; wait_clk(Q); scl_m = 1; wait_clk(H); sda_m = 0; wait_clk(H); scl_m = 0;
    endtask

    task automatic bus_stop();
        wait_clk(Q); sda_m = 0; wait_clk(Q); scl_m = 1; wait_clk(H); sda_m = 1; wait_clk(H);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) bit_out(d[i]);
        bit_in(b);
        ack = ~b;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            d[i] = b;
        end
        bit_out(~give_ack);
    endtask

    function automatic logic [7:0] ctrl(input logic [1:0] blk, input logic rd);
        return {4'b1010, 1'b0, blk, rd};
    endfunction

    // Acknowledge polling; leaves the bus in a write transfer after an accepted control byte.
    task automatic poll_ready(input logic [1:0] blk, output int polls, output logic got);
        logic ack;
        polls = 0; got = 0;
        while (!got && polls < POLL_LIMIT) begin
            bus_start();
            send_byte(ctrl(blk, 1'b0), ack);
            if (ack) got = 1;
            else begin bus_stop(); polls++; end
        end
    endtask

    // After an accepted write control byte: offset, repeated START, read control byte, one byte with NACK.
    task automatic finish_random_read(input string req, input logic [1:0] blk, input logic [7:0] off,
                                      output logic [7:0] d);
        logic ack;
        send_byte(off, ack);
        check(req, ack, 1'b1);
        bus_start();
        send_byte(ctrl(blk, 1'b1), ack);
        check(req, ack, 1'b1);
        recv_byte(d, 1'b0);
        bus_stop();
    endtask

    initial begin
        wait_clk(150_000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        if (!finished) begin
            $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
            $finish;
        end
    end

    initial begin
        logic ack, got;
        logic [7:0] d;
        int polls;
        wait_clk(5);
        rst_n = 1;
        wait_clk(3);

        // R10: released after reset; R7 current-address read of erased array.
        check("R10 sda released", sda_oe, 1'b0);
        bus_start();
        send_byte(ctrl(2'd0, 1'b1), ack);
        check("R7 ctrl read ack", ack, 1'b1);
        recv_byte(d, 1'b1);
        check("R10 erased byte", d, 8'hFF);
        recv_byte(d, 1'b0);
        check("R7 next byte erased", d, 8'hFF);
        bus_stop();

        // Vector table: byte write, acknowledge polling, random read back.
        for (int v = 0; v < 8; v++) begin
            bus_start();
            send_byte(ctrl(VEC[v][17:16], 1'b0), ack); check("R3 ctrl ack", ack, 1'b1);
            send_byte(VEC[v][15:8], ack);              check("R3 offset ack", ack, 1'b1);
            send_byte(VEC[v][7:0], ack);               check("R3 data ack", ack, 1'b1);
            bus_stop();
            poll_ready(VEC[v][17:16], polls, got);
            check("R5 first poll refused", (polls >= 1), 1'b1);
            check("R5 ready again", got, 1'b1);
            finish_random_read("R8 random read", VEC[v][17:16], VEC[v][15:8], d);
            check("R3 read back", d, VEC[v][7:0]);
        end

        // R2: every block keeps its own data.
        for (int v = 0; v < 8; v++) begin
            bus_start();
            send_byte(ctrl(VEC[v][17:16], 1'b0), ack);
            check("R2 ctrl ack", ack, 1'b1);
            finish_random_read("R2 random read", VEC[v][17:16], VEC[v][15:8], d);
            check("R2 block data", d, VEC[v][7:0]);
        end

        // R1: wrong device nibble refused and later bytes ignored; bit 3 don't-care.
        bus_start();
        send_byte(8'hB0, ack); check("R1 bad nibble nack", ack, 1'b0);
        send_byte(8'hA0, ack); check("R1 ignored until START", ack, 1'b0);
        bus_stop();
        bus_start();
        send_byte(8'hA8, ack); check("R1 bit3 ignored", ack, 1'b1);
        finish_random_read("R1 read", 2'd0, 8'h00, d);
        check("R1 data via bit3 ctrl", d, 8'h11);

        // R4: page write of 18 bytes at block 1 offset 0x3C.
        bus_start();
        send_byte(ctrl(2'd1, 1'b0), ack); check("R4 ctrl ack", ack, 1'b1);
        send_byte(8'h3C, ack);            check("R4 offset ack", ack, 1'b1);
        for (int i = 0; i < 18; i++) begin
            send_byte(8'h80 + 8'(i), ack);
            check("R4 data ack", ack, 1'b1);
        end
        bus_stop();
        poll_ready(2'd1, polls, got);
        check("R5 page poll refused", (polls >= 1), 1'b1);
        check("R5 page ready", got, 1'b1);
        bus_stop();
        // R6: STOP without data leaves no write cycle.
        bus_start();
        send_byte(ctrl(2'd1, 1'b1), ack); check("R6 no write cycle", ack, 1'b1);
        recv_byte(d, 1'b0);
        check("R7 pointer after page write", d, 8'h82);
        bus_stop();

        // R4/R9: sequential read of the page and the first byte of the next page.
        bus_start();
        send_byte(ctrl(2'd1, 1'b0), ack);
        send_byte(8'h30, ack);
        bus_start();
        send_byte(ctrl(2'd1, 1'b1), ack); check("R9 read ctrl ack", ack, 1'b1);
        for (int o = 0; o < 17; o++) begin
            int idx;
            logic [7:0] exp;
            recv_byte(d, (o < 16));
            idx = (o + 16 - 12) % 16;
            if (idx + 16 < 18) idx = idx + 16;
            exp = (o < 16) ? (8'h80 + 8'(idx)) : 8'hFF;
            check("R4 page wrap content", d, exp);
        end
        bus_stop();

        // R9: wrap from 1023 to 0, release after NACK and STOP.
        bus_start();
        send_byte(ctrl(2'd3, 1'b0), ack);
        send_byte(8'hFF, ack);
        bus_start();
        send_byte(ctrl(2'd3, 1'b1), ack);
        recv_byte(d, 1'b1); check("R9 last location", d, 8'h5A);
        recv_byte(d, 1'b0); check("R9 wrap to zero", d, 8'h11);
        bus_stop();
        wait_clk(2);
        check("R9 released after stop", sda_oe, 1'b0);

        // R12: repeated START discards buffered data.
        bus_start();
        send_byte(ctrl(2'd0, 1'b0), ack);
        send_byte(8'h50, ack);
        send_byte(8'hAA, ack); check("R12 data ack", ack, 1'b1);
        bus_start();
        send_byte(ctrl(2'd0, 1'b1), ack);
        recv_byte(d, 1'b0);
        bus_stop();
        bus_start();
        send_byte(ctrl(2'd0, 1'b0), ack); check("R12 no write cycle", ack, 1'b1);
        finish_random_read("R12 read", 2'd0, 8'h50, d);
        check("R12 nothing committed", d, 8'hFF);

        // R10: a second reset erases the array.
        rst_n = 0; wait_clk(3); rst_n = 1; wait_clk(3);
        check("R10 sda released after reset", sda_oe, 1'b0);
        bus_start();
        send_byte(ctrl(2'd0, 1'b0), ack);
        finish_random_read("R10 read", 2'd0, 8'h00, d);
        check("R10 erased after reset", d, 8'hFF);

        check("R11 drive changes only with SCL low", drv_viol, 0);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule